// File: doc/BRIEF.md
# Dual Tournament Parent Selector

This block picks parents for a hardware genetic search. The population lives in an external fitness memory. On each selection round, two tournament engines run side by side. Each engine draws one random contestant per clock, reads that contestant's fitness through its own read port, and keeps the best one seen so far. When the configured number of draws is done, both winners appear together with a one-cycle valid strobe. So every round yields a pair of parents.

The contestant count, the population size and the fitness width are configuration inputs. They are captured when a round starts, so they can change between rounds.

An optional elitism tracker watches every fitness read that the engines make. It holds the best individual seen since the last generation clear, so the surrounding logic can carry that individual into the next generation.

Top module: `tsel_top`

## Requirements
- R1: After reset, `sel_valid` and `elite_vld` are 0.
- R2: The contestant count is set by `cfg_contest`, where code 0/1/2/3 gives 2/4/8/16 draws. A round accepted at clock edge k makes its draws at edges k+1 through k+N. `sel_valid` is 1 only in the cycle that follows edge k+N.
- R3: The population size is set by `cfg_pop`, where code 0/1/2/3 gives 32/64/128/256 individuals. During each draw, the read address equals the random input masked to its low 5/6/7/8 bits.
- R4: Each winner is the draw with the largest fitness, compared unsigned.
- R5: When fitness values are equal, the earlier draw wins.
- R6: With `cfg_fit_wide`=0, only the low 16 bits of the read data count. The reported fitness has its upper 16 bits forced to 0. With `cfg_fit_wide`=1, all 32 bits count.
- R7: The two engines use separate random inputs and separate read ports. Both finish in the same cycle.
- R8: A `start` pulse during a running round is ignored. It changes neither the timing nor the result of that round.
- R9: With `cfg_elite_en`=1, the elite register takes any draw that beats it strictly, or any draw when it is empty. When both engines draw in the same cycle, engine A wins a tie. With `cfg_elite_en`=0, the elite register is left unchanged.
- R10: `gen_clr` empties the elite register on the next edge. If `gen_clr` coincides with a draw, the clear wins and that draw is discarded.
- R11: The winner outputs hold their values after `sel_valid` until the next round starts drawing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a selection round when idle |
| cfg_contest | input | 2 | Contestant count code |
| cfg_pop | input | 2 | Population size code |
| cfg_fit_wide | input | 1 | 1: 32-bit fitness, 0: 16-bit fitness |
| cfg_elite_en | input | 1 | Enable elite tracking |
| gen_clr | input | 1 | Clear the elite register |
| rnd_a | input | 8 | Random index for engine A |
| rnd_b | input | 8 | Random index for engine B |
| rd_addr_a | output | 8 | Fitness memory address, engine A |
| rd_data_a | input | 32 | Fitness read data, same cycle, engine A |
| rd_addr_b | output | 8 | Fitness memory address, engine B |
| rd_data_b | input | 32 | Fitness read data, same cycle, engine B |
| sel_valid | output | 1 | Winner pair ready (one cycle) |
| win_idx_a | output | 8 | Winner index, engine A |
| win_fit_a | output | 32 | Winner fitness, engine A |
| win_idx_b | output | 8 | Winner index, engine B |
| win_fit_b | output | 32 | Winner fitness, engine B |
| elite_vld | output | 1 | Elite register holds an individual |
| elite_idx | output | 8 | Elite index |
| elite_fit | output | 32 | Elite fitness |

## Verification
Two functions can fall in the same cycle: a generation clear and an elite update from a draw. The bench raises `gen_clr` during chosen draw cycles, including the last draw of a round. A bench-side elite model applies clear-wins priority and then replays the later draws. After the round ends, the elite valid flag, index and fitness are compared with that model.

// File: rtl/tsel_pkg.sv
// Shared widths and the candidate record used by the selection logic.
package tsel_pkg;
    localparam int IDX_W    = 8;   // index width for the largest population
    localparam int FIT_W    = 32;  // widest fitness
    localparam int HALF_W   = 16;  // narrow fitness mode
    localparam int CNT_W    = 5;   // holds the largest contestant count
    localparam int SEL_MAX  = 3;   // largest config code

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [FIT_W-1:0] fit;
    } cand_t;
endpackage

// File: rtl/tsel_engine.sv
// One tournament engine. It draws a masked random index each busy cycle,
// reads its fitness in the same cycle, and keeps the strictly larger one.
// Assumes: cnt_lim >= 2 and the config inputs stay stable while busy.
module tsel_engine
    import tsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] cnt_lim,
    input  logic [IDX_W-1:0] mask,
    input  logic             fit_wide,
    input  logic [IDX_W-1:0] rnd,
    input  logic [FIT_W-1:0] rd_data,
    output logic [IDX_W-1:0] rd_addr,
    output logic             busy,
    output logic             done,
    output cand_t            best,
    output cand_t            draw_cand
);
    logic [CNT_W-1:0] cnt;
    logic [FIT_W-1:0] fit_eff;
    logic             take;

    // Form the masked address and the fitness as seen in the current width mode.
    always_comb begin
        rd_addr   = rnd & mask;
        fit_eff   = fit_wide ? rd_data : {{(FIT_W-HALF_W){1'b0}}, rd_data[HALF_W-1:0]};
        draw_cand = '{idx: rd_addr, fit: fit_eff};
        take      = busy && ((cnt == '0) || (fit_eff > best.fit));
    end

    // Sequence the draws and keep the running winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            best <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                cnt <= cnt + 1'b1;
                if (take) best <= draw_cand;
                if (cnt == cnt_lim - 1'b1) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (go) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < cnt_lim)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> (best.fit >= $past(best.fit))); // R4
endmodule

// File: rtl/tsel_elite.sv
// Elite tracker. It picks the better of the two simultaneous draws (A on a
// tie) and stores it if it strictly beats the held individual.
// Assumes: both engines draw in the same cycles.
module tsel_elite
    import tsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  en,
    input  logic  draw,
    input  cand_t cand_a,
    input  cand_t cand_b,
    output logic  elite_vld,
    output cand_t elite
);
    cand_t pick;
    logic  upd;

    // Choose the stronger draw of the cycle and decide whether it is kept.
    always_comb begin
        pick = (cand_b.fit > cand_a.fit) ? cand_b : cand_a;
        upd  = en && draw && (!elite_vld || (pick.fit > elite.fit));
    end

    // Hold the elite; a clear has priority over an update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elite_vld <= 1'b0;
            elite     <= '0;
        end else if (clr) begin
            elite_vld <= 1'b0;
            elite     <= '0;
        end else if (upd) begin
            elite_vld <= 1'b1;
            elite     <= pick;
        end
    end

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !elite_vld); // R10
    AST_ELITE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (elite_vld && !clr) |=> (elite_vld && elite.fit >= $past(elite.fit))); // R9
    AST_ELITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(elite)); // R9
endmodule

// File: rtl/tsel_top.sv
// Dual tournament parent selector. It captures the configuration when a
// round is accepted, runs two engines in lockstep and feeds their draws to
// the elite tracker. Assumes: the fitness memory answers in the same cycle.
module tsel_top
    import tsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       cfg_contest,
    input  logic [1:0]       cfg_pop,
    input  logic             cfg_fit_wide,
    input  logic             cfg_elite_en,
    input  logic             gen_clr,
    input  logic [IDX_W-1:0] rnd_a,
    input  logic [IDX_W-1:0] rnd_b,
    output logic [IDX_W-1:0] rd_addr_a,
    input  logic [FIT_W-1:0] rd_data_a,
    output logic [IDX_W-1:0] rd_addr_b,
    input  logic [FIT_W-1:0] rd_data_b,
    output logic             sel_valid,
    output logic [IDX_W-1:0] win_idx_a,
    output logic [FIT_W-1:0] win_fit_a,
    output logic [IDX_W-1:0] win_idx_b,
    output logic [FIT_W-1:0] win_fit_b,
    output logic             elite_vld,
    output logic [IDX_W-1:0] elite_idx,
    output logic [FIT_W-1:0] elite_fit
);
    localparam int NENG = 2;

    logic [CNT_W-1:0] lim_q;
    logic [IDX_W-1:0] mask_q;
    logic             wide_q;
    logic             go;
    logic [IDX_W-1:0] rnd_v     [NENG];
    logic [FIT_W-1:0] rdata_v   [NENG];
    logic [IDX_W-1:0] raddr_v   [NENG];
    logic [NENG-1:0]  busy_v;
    logic [NENG-1:0]  done_v;
    cand_t            best_v    [NENG];
    cand_t            draw_v    [NENG];
    cand_t            elite;

    // Accept a round only when both engines are idle.
    assign go = start && (busy_v == '0);

    // Capture the count, mask and width for the round being accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q  <= CNT_W'(2);
            mask_q <= '1;
            wide_q <= 1'b1;
        end else if (go) begin
            lim_q  <= CNT_W'(2) << cfg_contest;
            mask_q <= {IDX_W{1'b1}} >> (2'(SEL_MAX) - cfg_pop);
            wide_q <= cfg_fit_wide;
        end
    end

    assign rnd_v[0]   = rnd_a;
    assign rnd_v[1]   = rnd_b;
    assign rdata_v[0] = rd_data_a;
    assign rdata_v[1] = rd_data_b;

    for (genvar e = 0; e < NENG; e++) begin : g_eng
        tsel_engine u_eng (
            .clk       (clk),
            .rst_n     (rst_n),
            .go        (go),
            .cnt_lim   (lim_q),
            .mask      (mask_q),
            .fit_wide  (wide_q),
            .rnd       (rnd_v[e]),
            .rd_data   (rdata_v[e]),
            .rd_addr   (raddr_v[e]),
            .busy      (busy_v[e]),
            .done      (done_v[e]),
            .best      (best_v[e]),
            .draw_cand (draw_v[e])
        );
    end

    tsel_elite u_elite (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (gen_clr),
        .en        (cfg_elite_en),
        .draw      (busy_v[0]),
        .cand_a    (draw_v[0]),
        .cand_b    (draw_v[1]),
        .elite_vld (elite_vld),
        .elite     (elite)
    );

    // Drive the outward ports from the engine and elite state.
    always_comb begin
        rd_addr_a = raddr_v[0];
        rd_addr_b = raddr_v[1];
        sel_valid = done_v[0];
        win_idx_a = best_v[0].idx;
        win_fit_a = best_v[0].fit;
        win_idx_b = best_v[1].idx;
        win_fit_b = best_v[1].fit;
        elite_idx = elite.idx;
        elite_fit = elite.fit;
    end

    AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_v[0] == done_v[1]) && (busy_v[0] == busy_v[1])); // R7
    AST_IDX_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (((win_idx_a | win_idx_b) & ~mask_q) == '0)); // R3
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_v[0] && !go) |=> $stable(best_v[0]) && $stable(best_v[1])); // R11
endmodule

// File: tb/tsel_top_test.sv
`timescale 1ns/1ps
module tsel_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  cfg_contest, cfg_pop;
    logic        cfg_fit_wide, cfg_elite_en, gen_clr;
    logic [7:0]  rnd_a, rnd_b, rd_addr_a, rd_addr_b;
    logic [31:0] rd_data_a, rd_data_b;
    logic        sel_valid, elite_vld;
    logic [7:0]  win_idx_a, win_idx_b, elite_idx;
    logic [31:0] win_fit_a, win_fit_b, elite_fit;

    logic [31:0] mem [256];
    int checks = 0;
    int errors = 0;

    // Bench elite model state.
    logic        m_ev;
    logic [7:0]  m_ei;
    logic [31:0] m_ef;

    always #2.5 clk = ~clk;

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];

    tsel_top uut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] f_mask(input logic [1:0] p);
        return 8'hFF >> (3 - p);
    endfunction

    function automatic logic [31:0] f_eff(input logic [31:0] v, input logic w);
        return w ? v : {16'h0, v[15:0]};
    endfunction

    // Run one round; clr_at selects a draw cycle for gen_clr (-1: none),
    // restart pulses start during draw 1.
    task automatic run_round(input logic [1:0] cs, input logic [1:0] ps, input logic w,
                             input logic een, input int clr_at, input logic restart);
        logic [7:0]  ra [16];
        logic [7:0]  rb [16];
        int          n;
        logic [7:0]  m, bia, bib, pi;
        logic [31:0] bfa, bfb, fa, fb, pf;
        n = 2 << cs;
        m = f_mask(ps);
        for (int i = 0; i < 16; i++) begin
            ra[i] = 8'($urandom);
            rb[i] = 8'($urandom);
        end
        @(negedge clk);
        start = 1'b1; cfg_contest = cs; cfg_pop = ps; cfg_fit_wide = w;
        cfg_elite_en = een; rnd_a = 8'hFF; rnd_b = 8'hFF;
        @(posedge clk);
        bia = 0; bib = 0; bfa = 0; bfb = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = (restart && i == 1);
            cfg_contest = 2'($urandom); cfg_pop = 2'($urandom); cfg_fit_wide = 1'($urandom);
            rnd_a = ra[i]; rnd_b = rb[i];
            gen_clr = (i == clr_at);
            #1;
            check("R3 addr_a", rd_addr_a, ra[i] & m);
            check("R3 addr_b", rd_addr_b, rb[i] & m);
            if (i == 0) check("R11 held before first draw edge", sel_valid, 0);
            fa = f_eff(mem[ra[i] & m], w);
            fb = f_eff(mem[rb[i] & m], w);
            if (i == 0 || fa > bfa) begin bia = ra[i] & m; bfa = fa; end
            if (i == 0 || fb > bfb) begin bib = rb[i] & m; bfb = fb; end
            if (fb > fa) begin pi = rb[i] & m; pf = fb; end
            else begin pi = ra[i] & m; pf = fa; end
            if (i == clr_at) begin m_ev = 0; m_ei = 0; m_ef = 0; end
            else if (een && (!m_ev || pf > m_ef)) begin m_ev = 1; m_ei = pi; m_ef = pf; end
            @(posedge clk);
        end
        @(negedge clk);
        start = 1'b0; gen_clr = 1'b0;
        check("R2 valid after last draw", sel_valid, 1);
        check("R4 R5 R7 idx_a", win_idx_a, bia);
        check("R4 R6 R7 fit_a", win_fit_a, bfa);
        check("R4 R5 R7 idx_b", win_idx_b, bib);
        check("R4 R6 R7 fit_b", win_fit_b, bfb);
        check("R9 R10 elite_vld", elite_vld, m_ev);
        check("R9 R10 elite_idx", elite_idx, m_ei);
        check("R9 R10 elite_fit", elite_fit, m_ef);
        @(negedge clk);
        check("R2 valid one cycle", sel_valid, 0);
        check("R11 idx_a held", win_idx_a, bia);
        check("R11 fit_b held", win_fit_b, bfb);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; start = 0; cfg_contest = 0; cfg_pop = 0; cfg_fit_wide = 1;
        cfg_elite_en = 1; gen_clr = 0; rnd_a = 0; rnd_b = 0;
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        m_ev = 0; m_ei = 0; m_ef = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 sel_valid", sel_valid, 0);
        check("R1 elite_vld", elite_vld, 0);

        // Directed: every count and population code.
        for (int c = 0; c < 4; c++)
            for (int p = 0; p < 4; p++) run_round(2'(c), 2'(p), 1, 1, -1, 0);

        // R5: all equal fitness, the first draw must win.
        for (int i = 0; i < 256; i++) mem[i] = 32'h0000_4444;
        run_round(2'd3, 2'd3, 1, 1, -1, 0);

        // R6: upper halves differ, lower halves equal; the narrow mode sees ties.
        for (int i = 0; i < 256; i++) mem[i] = {16'($urandom), 16'h0005};
        run_round(2'd2, 2'd3, 0, 1, -1, 0);
        run_round(2'd2, 2'd3, 1, 1, -1, 0);

        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        // R8: start during a round is ignored.
        run_round(2'd1, 2'd2, 1, 1, -1, 1);
        // R9: elite disabled leaves the register unchanged.
        run_round(2'd3, 2'd3, 1, 0, -1, 0);
        // R10: clear on a middle draw and on the last draw.
        run_round(2'd2, 2'd3, 1, 1, 3, 0);
        run_round(2'd1, 2'd3, 1, 1, 3, 0);
        // R10: clear while idle.
        @(negedge clk); gen_clr = 1; @(negedge clk); gen_clr = 0;
        m_ev = 0; m_ei = 0; m_ef = 0;
        check("R10 idle clear", elite_vld, 0);

        // Random rounds.
        for (int k = 0; k < 40; k++)
            run_round(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                      ($urandom % 3 == 0) ? int'($urandom % 4) : -1, 1'($urandom));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule